// File: doc/BRIEF.md
# Target Bus Ownership Controller

This block lets a host take over the memory bus of an external 8-bit processor. The host issues single-cycle commands. The block drives the target's active-low reset and bus-request outputs and watches the target's active-low bus-grant input. It also switches the address and strobe drivers between driven and high-impedance. A 2-bit ownership state tells the host whether the target is held in reset or running, and whether the host currently owns the bus.

Acquiring the bus is a wait with a time-out, counted in slow ticks from a parameterised prescaler. If the grant never arrives, the block falls back to the state it started from. A run command given while the bus is held applies a timed reset pulse and keeps the bus afterwards. A single-step command briefly gives the bus back and then requests it again. While a wait, pulse or gap is in progress a busy flag is high. During that time every command except Reset is dropped. The memory cycles and the data path are outside this block.

Top module: `bus_own_ctrl`

## Requirements
- R1: After rst_n is released, own_state is 0, tgt_reset_n is 0, bus_req_n is 1, drv_en is 0 and busy is 0. State codes are: 0 reset-held-idle, 1 reset-held-with-bus, 2 running, 3 running-with-bus. In state 0 the drivers are never enabled.
- R2: Command code 0 (Reset) is accepted in any state and phase, including during a wait. One cycle later own_state is 0, busy is 0, drv_en is 0, tgt_reset_n is 0 and bus_req_n is 1.
- R3: Request (code 1) in state 0 lowers bus_req_n and raises tgt_reset_n on the next edge, and busy goes high. When the synchronised grant is seen low, drv_en goes to 1 and own_state goes to 1.
- R4: If no grant is seen after a Request from state 0, busy stays high for exactly ACK_TICKS*TICK_DIV+1 cycles. The block then returns to idle in state 0 with tgt_reset_n 0 and bus_req_n 1. The tick counter stops at zero.
- R5: Request in state 2 lowers bus_req_n and moves to state 3 with drv_en 1 on a grant. On time-out it stays in state 2 with bus_req_n 1 and drv_en 0. In state 2 the drivers are never enabled.
- R6: Release (code 2) moves state 1 to state 0 with tgt_reset_n 0, and state 3 to state 2. In both cases drv_en is 0 and bus_req_n is 1 one cycle later.
- R7: Run (code 3) in state 0 raises tgt_reset_n and moves to state 2 in one cycle. Run in state 1 holds tgt_reset_n low and drv_en low for exactly PULSE_CYCLES cycles, then enters state 3 with drv_en 1 and tgt_reset_n 1.
- R8: Restart (code 4) in state 2 or 3 holds tgt_reset_n low for exactly PULSE_CYCLES cycles and leaves own_state, drv_en and bus_req_n unchanged.
- R9: M_Cycle (code 5) in state 3 sets drv_en to 0 and holds bus_req_n high for exactly GAP_CYCLES cycles. It then lowers bus_req_n and waits for the grant, after which drv_en returns to 1. On time-out the block stays in state 3 with bus_req_n low and drv_en 0. drv_en is never 1 while bus_req_n is 1.
- R10: A command not listed for the current state is ignored, as are codes 6 and 7. While busy is high, every command other than Reset is ignored.
- R11: A low grant outside an acquisition wait changes nothing. The grant passes through SYNC_STAGES synchronising flops before it is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_code | input | 3 | Command code (0 Reset, 1 Request, 2 Release, 3 Run, 4 Restart, 5 M_Cycle) |
| grant_n | input | 1 | Target bus grant, active low, asynchronous |
| tgt_reset_n | output | 1 | Target reset, active low |
| bus_req_n | output | 1 | Target bus request, active low |
| drv_en | output | 1 | Enable for address and strobe drivers; 0 means high impedance |
| own_state | output | 2 | Ownership state code |
| busy | output | 1 | Wait, pulse or gap in progress |

## Verification
Every output is a register. A command sampled at one edge therefore shows its first effect at that same edge, and the bench compares it at the following falling edge. Durations are counted in falling edges while the relevant output holds its value: the time-out window is ACK_TICKS*TICK_DIV+1 cycles, the reset pulse PULSE_CYCLES and the request gap GAP_CYCLES. Results of a grant-terminated wait are compared only once busy has fallen, because the grant latency belongs to the target model. A bench target model returns the grant a few cycles after the request, and a bench flag can suppress it.

// File: rtl/bus_own_pkg.sv
package bus_own_pkg;

  typedef enum logic [1:0] {
    OWN_RESET      = 2'd0,
    OWN_RESET_HELD = 2'd1,
    OWN_RUN        = 2'd2,
    OWN_RUN_HELD   = 2'd3
  } own_state_e;

  typedef enum logic [2:0] {
    CMD_RESET   = 3'd0,
    CMD_REQUEST = 3'd1,
    CMD_RELEASE = 3'd2,
    CMD_RUN     = 3'd3,
    CMD_RESTART = 3'd4,
    CMD_MCYCLE  = 3'd5,
    CMD_RSVD6   = 3'd6,
    CMD_RSVD7   = 3'd7
  } own_cmd_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WAIT  = 2'd1,
    PH_PULSE = 2'd2,
    PH_GAP   = 2'd3
  } own_phase_e;

endpackage

// File: rtl/bus_own_tick.sv
module bus_own_tick #(
  parameter int unsigned TICK_DIV = 12_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int unsigned W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [W-1:0] LAST = W'(TICK_DIV - 1);

  logic [W-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (restart || tick) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_tick_wraps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));

endmodule

// File: rtl/bus_own_ackwait.sv
module bus_own_ackwait #(
  parameter int unsigned ACK_TICKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic tick,
  output logic expired
);
  localparam int unsigned W = $clog2(ACK_TICKS + 1);

  logic [W-1:0] cnt_q, cnt_d;

  assign expired = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)                  cnt_d = W'(ACK_TICKS);
    else if (tick && !expired) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_timer_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired);

endmodule

// File: rtl/bus_own_span.sv
module bus_own_span #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q, cnt_d;

  assign done = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)       cnt_d = load_val;
    else if (!done) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_span_counts_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/bus_own_ctrl.sv
module bus_own_ctrl
  import bus_own_pkg::*;
#(
  parameter int unsigned TICK_DIV     = 12_500_000,
  parameter int unsigned ACK_TICKS    = 20,
  parameter int unsigned PULSE_CYCLES = 1250,
  parameter int unsigned GAP_CYCLES   = 2,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_code,
  input  logic       grant_n,
  output logic       tgt_reset_n,
  output logic       bus_req_n,
  output logic       drv_en,
  output logic [1:0] own_state,
  output logic       busy
);
  localparam int unsigned SPAN_MAX = (PULSE_CYCLES > GAP_CYCLES) ? PULSE_CYCLES : GAP_CYCLES;
  localparam int unsigned SW       = $clog2(SPAN_MAX + 1);
  localparam logic [SW-1:0] PULSE_LOAD = SW'(PULSE_CYCLES - 1);
  localparam logic [SW-1:0] GAP_LOAD   = SW'(GAP_CYCLES - 1);

  // grant synchroniser
  logic [SYNC_STAGES-1:0] sync_q;
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[gi] <= 1'b1;
        else if (gi == 0) sync_q[gi] <= grant_n;
        else sync_q[gi] <= sync_q[(gi == 0) ? 0 : gi - 1];
      end
    end
  endgenerate

  logic grant_seen;
  assign grant_seen = !sync_q[SYNC_STAGES-1];

  own_state_e state_q, state_d, goal_q, goal_d;
  own_phase_e phase_q, phase_d;
  logic       rst_out_q, rst_out_d;
  logic       req_out_q, req_out_d;
  logic       drv_q, drv_d;
  logic       wait_load, span_load, tick, wait_expired, span_done;
  logic [SW-1:0] span_val;
  own_cmd_e   cmd;

  assign cmd = own_cmd_e'(cmd_code);

  bus_own_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(wait_load), .tick(tick));

  bus_own_ackwait #(.ACK_TICKS(ACK_TICKS)) u_wait (
    .clk(clk), .rst_n(rst_n), .load(wait_load), .tick(tick), .expired(wait_expired));

  bus_own_span #(.W(SW)) u_span (
    .clk(clk), .rst_n(rst_n), .load(span_load), .load_val(span_val), .done(span_done));

  always_comb begin
    state_d   = state_q;
    goal_d    = goal_q;
    phase_d   = phase_q;
    rst_out_d = rst_out_q;
    req_out_d = req_out_q;
    drv_d     = drv_q;
    wait_load = 1'b0;
    span_load = 1'b0;
    span_val  = '0;
    if (cmd_valid && cmd == CMD_RESET) begin
      state_d   = OWN_RESET;
      phase_d   = PH_IDLE;
      rst_out_d = 1'b0;
      req_out_d = 1'b1;
      drv_d     = 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (cmd_valid) begin
          case (cmd)
            CMD_REQUEST: begin
              if (state_q == OWN_RESET || state_q == OWN_RUN) begin
                req_out_d = 1'b0;
                phase_d   = PH_WAIT;
                wait_load = 1'b1;
                if (state_q == OWN_RESET) begin
                  rst_out_d = 1'b1;
                  goal_d    = OWN_RESET_HELD;
                end else begin
                  goal_d    = OWN_RUN_HELD;
                end
              end
            end
            CMD_RELEASE: begin
              if (state_q == OWN_RESET_HELD) begin
                drv_d     = 1'b0;
                req_out_d = 1'b1;
                rst_out_d = 1'b0;
                state_d   = OWN_RESET;
              end else if (state_q == OWN_RUN_HELD) begin
                drv_d     = 1'b0;
                req_out_d = 1'b1;
                state_d   = OWN_RUN;
              end
            end
            CMD_RUN: begin
              if (state_q == OWN_RESET) begin
                rst_out_d = 1'b1;
                state_d   = OWN_RUN;
              end else if (state_q == OWN_RESET_HELD) begin
                drv_d     = 1'b0;
                rst_out_d = 1'b0;
                phase_d   = PH_PULSE;
                span_load = 1'b1;
                span_val  = PULSE_LOAD;
                goal_d    = OWN_RUN_HELD;
              end
            end
            CMD_RESTART: begin
              if (state_q == OWN_RUN || state_q == OWN_RUN_HELD) begin
                rst_out_d = 1'b0;
                phase_d   = PH_PULSE;
                span_load = 1'b1;
                span_val  = PULSE_LOAD;
                goal_d    = state_q;
              end
            end
            CMD_MCYCLE: begin
              if (state_q == OWN_RUN_HELD) begin
                drv_d     = 1'b0;
                req_out_d = 1'b1;
                phase_d   = PH_GAP;
                span_load = 1'b1;
                span_val  = GAP_LOAD;
                goal_d    = OWN_RUN_HELD;
              end
            end
            default: ;
          endcase
        end
        PH_WAIT: begin
          if (grant_seen) begin
            drv_d   = 1'b1;
            state_d = goal_q;
            phase_d = PH_IDLE;
          end else if (wait_expired) begin
            phase_d = PH_IDLE;
            if (state_q == OWN_RESET) begin
              req_out_d = 1'b1;
              rst_out_d = 1'b0;
            end else if (state_q == OWN_RUN) begin
              req_out_d = 1'b1;
            end
          end
        end
        PH_PULSE: begin
          if (span_done) begin
            rst_out_d = 1'b1;
            drv_d     = (goal_q == OWN_RUN_HELD);
            state_d   = goal_q;
            phase_d   = PH_IDLE;
          end
        end
        PH_GAP: begin
          if (span_done) begin
            req_out_d = 1'b0;
            phase_d   = PH_WAIT;
            wait_load = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= OWN_RESET;
      goal_q    <= OWN_RESET;
      phase_q   <= PH_IDLE;
      rst_out_q <= 1'b0;
      req_out_q <= 1'b1;
      drv_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      goal_q    <= goal_d;
      phase_q   <= phase_d;
      rst_out_q <= rst_out_d;
      req_out_q <= req_out_d;
      drv_q     <= drv_d;
    end
  end

  assign tgt_reset_n = rst_out_q;
  assign bus_req_n   = req_out_q;
  assign drv_en      = drv_q;
  assign own_state   = state_q;
  assign busy        = (phase_q != PH_IDLE);

  assert_drive_needs_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drv_q |-> !req_out_q);
  assert_no_drive_in_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == OWN_RESET) |-> !drv_q);
  assert_no_drive_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == OWN_RUN) |-> !drv_q);
  assert_idle_reset_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == OWN_RESET && phase_q == PH_IDLE) |-> !rst_out_q);
  assert_pulse_holds_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_PULSE) |-> !rst_out_q);
  assert_reset_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 3'd0) |=> (state_q == OWN_RESET && phase_q == PH_IDLE));

endmodule

// File: tb/bus_own_ctrl_tb_top.sv
`timescale 1ns/1ps
module bus_own_ctrl_tb_top;
  localparam int TDIV = 4, TACK = 3, TPULSE = 5, TGAP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_code = 3'd0;
  logic respond = 1'b0, force_low = 1'b0;
  logic [2:0] dly;
  logic grant_n;
  logic tgt_reset_n, bus_req_n, drv_en, busy;
  logic [1:0] own_state;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  bus_own_ctrl #(.TICK_DIV(TDIV), .ACK_TICKS(TACK), .PULSE_CYCLES(TPULSE),
                 .GAP_CYCLES(TGAP), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .grant_n(grant_n), .tgt_reset_n(tgt_reset_n), .bus_req_n(bus_req_n),
    .drv_en(drv_en), .own_state(own_state), .busy(busy));

  // target model: grant follows request after three cycles
  always @(posedge clk or negedge rst_n)
    if (!rst_n) dly <= 3'b111;
    else        dly <= {dly[1:0], bus_req_n};
  assign grant_n = force_low ? 1'b0 : (respond ? dly[2] : 1'b1);

  typedef struct {
    string      tag;
    logic [1:0] st;
    logic       rn, qn, dv, bz;
  } exp_t;
  exp_t sb_q[$];

  task automatic expect_now(input string tag, input logic [1:0] st,
                            input logic rn, input logic qn, input logic dv, input logic bz);
    exp_t e;
    e.tag = tag; e.st = st; e.rn = rn; e.qn = qn; e.dv = dv; e.bz = bz;
    sb_q.push_back(e);
  endtask

  // monitor
  always begin
    @(negedge clk);
    #1;
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_chk++;
      if (own_state !== e.st || tgt_reset_n !== e.rn || bus_req_n !== e.qn ||
          drv_en !== e.dv || busy !== e.bz) begin
        n_bad++;
        $display("FAIL %s: got st=%0d rst_n=%b req_n=%b drv=%b busy=%b exp st=%0d rst_n=%b req_n=%b drv=%b busy=%b",
                 e.tag, own_state, tgt_reset_n, bus_req_n, drv_en, busy,
                 e.st, e.rn, e.qn, e.dv, e.bz);
      end
    end
  end

  task automatic check_num(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d exp %0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] c);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_code  = c;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    for (int i = 0; i < 20000; i++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : driver
    int n;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    expect_now("R1 power-up", 2'd0, 0, 1, 0, 0);

    send(3'd2);
    expect_now("R10 release in state 0 ignored", 2'd0, 0, 1, 0, 0);
    send(3'd7);
    expect_now("R10 code 7 ignored", 2'd0, 0, 1, 0, 0);

    // R4 time-out from state 0
    send(3'd1);
    expect_now("R3 request drives lines", 2'd0, 1, 0, 0, 1);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check_num("R4 wait length", n, TACK*TDIV + 1);
    expect_now("R4 fallback", 2'd0, 0, 1, 0, 0);

    // R3 success
    respond = 1'b1;
    send(3'd1);
    wait_idle();
    expect_now("R3 acquired", 2'd1, 1, 0, 1, 0);
    send(3'd1);
    expect_now("R10 request in state 1 ignored", 2'd1, 1, 0, 1, 0);

    // R7 run from 1
    send(3'd3);
    expect_now("R7 pulse start drivers off", 2'd1, 0, 0, 0, 1);
    n = 0;
    while (!tgt_reset_n) begin n++; @(negedge clk); end
    check_num("R7 pulse length", n, TPULSE);
    expect_now("R7 run from held", 2'd3, 1, 0, 1, 0);

    // R8 restart in 3
    send(3'd4);
    n = 0;
    while (!tgt_reset_n) begin n++; @(negedge clk); end
    check_num("R8 pulse length in 3", n, TPULSE);
    expect_now("R8 restart keeps 3", 2'd3, 1, 0, 1, 0);

    // R10 command during pulse ignored
    send(3'd4);
    send(3'd5);
    wait_idle();
    expect_now("R10 mcycle during pulse ignored", 2'd3, 1, 0, 1, 0);

    // R9 m-cycle success
    send(3'd5);
    expect_now("R9 gap drivers off", 2'd3, 1, 1, 0, 1);
    n = 0;
    while (bus_req_n) begin n++; @(negedge clk); end
    check_num("R9 gap length", n, TGAP);
    wait_idle();
    expect_now("R9 mcycle reacquired", 2'd3, 1, 0, 1, 0);

    // R6 release 3 -> 2
    send(3'd2);
    expect_now("R6 release to running", 2'd2, 1, 1, 0, 0);
    send(3'd3);
    expect_now("R10 run in state 2 ignored", 2'd2, 1, 1, 0, 0);

    // R11 grant low while idle
    force_low = 1'b1;
    idle(6);
    expect_now("R11 stray grant ignored", 2'd2, 1, 1, 0, 0);
    force_low = 1'b0;
    idle(6);

    // R8 restart in 2
    send(3'd4);
    n = 0;
    while (!tgt_reset_n) begin n++; @(negedge clk); end
    check_num("R8 pulse length in 2", n, TPULSE);
    expect_now("R8 restart keeps 2", 2'd2, 1, 1, 0, 0);

    // R5 time-out then success from 2
    respond = 1'b0;
    send(3'd1);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check_num("R5 wait length", n, TACK*TDIV + 1);
    expect_now("R5 fallback stays 2", 2'd2, 1, 1, 0, 0);
    respond = 1'b1;
    send(3'd1);
    wait_idle();
    expect_now("R5 acquired from running", 2'd3, 1, 0, 1, 0);

    // R9 m-cycle time-out
    respond = 1'b0;
    idle(8);
    send(3'd5);
    wait_idle();
    expect_now("R9 mcycle timeout", 2'd3, 1, 0, 0, 0);
    send(3'd2);
    expect_now("R6 release after timeout", 2'd2, 1, 1, 0, 0);

    // R2 reset during a wait
    send(3'd1);
    idle(3);
    send(3'd0);
    expect_now("R2 reset aborts wait", 2'd0, 0, 1, 0, 0);

    // R7 run from 0
    send(3'd3);
    expect_now("R7 run from 0", 2'd2, 1, 1, 0, 0);

    // R6 release 1 -> 0
    send(3'd0);
    respond = 1'b1;
    send(3'd1);
    wait_idle();
    expect_now("R3 acquired again", 2'd1, 1, 0, 1, 0);
    send(3'd6);
    expect_now("R10 code 6 ignored", 2'd1, 1, 0, 1, 0);
    send(3'd2);
    expect_now("R6 release to reset", 2'd0, 0, 1, 0, 0);

    idle(3);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule